// File: doc/BRIEF.md
# Single-Channel Parameter-Driven DMA Engine

This block moves data between memory locations under the control of a parameter set held in a small internal parameter RAM. A host fills the parameter RAM through a write port, then pulses `start` with the byte address of a parameter set. The engine fetches that set, waits for synchronization events, and for each event moves either a single element or a whole frame over a valid/ready memory port. Each element is read from the source address and written to the destination address.

After every element, the source and destination addresses are each held, stepped up or stepped down by the element size, as set by their own mode fields. Element and frame counters track progress, and the element counter reloads from its own reload field. When the last element of the last frame is written, the engine can pulse a completion signal with a code taken from the options word. It then either stops or fetches a linked parameter set and carries on without host help. Synchronization events that arrive while the engine is busy are counted and serviced later.

A parameter set is six 32-bit words (24 bytes), stored little-endian at a byte address that is a multiple of 4:
word 0 options, word 1 source address, word 2 destination address, word 3 `{frame_count[31:16], element_count[15:0]}`, word 4 `element_reload[15:0]`, word 5 `link_address[15:0]`. The options word fields are:
- size [1:0]: 0 = 8 bit, 1 = 16 bit, 2 = 32 bit.
- source mode [3:2] and destination mode [5:4]: 0 = hold, 1 = increment, 2 = decrement, 3 = hold.
- frame sync [6].
- completion pulse enable [7].
- link [8].
- completion code [15:12].

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, `busy`, `mem_valid` and `done_pulse` are 0.
- R2: A `start` pulse while idle fetches the six-word set at byte address `start_addr` from the parameter RAM, and `busy` is 1 from the next cycle until the engine stops.
- R3: Options bits [1:0] select the element width (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes). `mem_size` carries this value, and only the low bytes of that width are moved, right-aligned on the data buses.
- R4: Options bits [3:2] (source) and [5:4] (destination) pick the address update after each element: 0 or 3 hold, 1 adds the element width in bytes, 2 subtracts it.
- R5: With options bit [6] clear, each synchronization event moves exactly one element. No element moves without an event.
- R6: A block is (frame_count + 1) frames of element_count elements each. When the element that is written has element_count equal to 1, element_count is reloaded from element_reload and frame_count is decremented, unless frame_count is 0, in which case the block is complete.
- R7: With options bit [6] set, each synchronization event moves all remaining elements of the current frame back to back.
- R8: Events that arrive while a transfer is in progress or a set is being fetched are counted (up to 2^PEND_W - 1) and each one is serviced later.
- R9: On block completion with options bit [7] set, `done_pulse` is high for one cycle with `done_code` equal to options bits [15:12]. With bit [7] clear, no pulse is produced.
- R10: On block completion with options bit [8] set, the set at byte address link_address is fetched and the transfer continues. With bit [8] clear, the engine goes idle, and later events cause no memory access.
- R11: While `mem_valid` is high and `mem_ready` is low, the request (address, direction, write data) and the counters stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Parameter RAM write strobe |
| host_waddr | input | PIDX_W (9) | Parameter RAM word index |
| host_wdata | input | 32 | Parameter RAM write data |
| start | input | 1 | Begin a transfer from the set at `start_addr` |
| start_addr | input | 16 | Byte address of the first parameter set |
| sync_evt | input | 1 | Synchronization event, one per cycle high |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the element |
| mem_size | output | 2 | Element width code |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_ready | input | 1 | Memory accepts or completes the request |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` on a read |
| busy | output | 1 | Engine holds an active parameter set |
| done_pulse | output | 1 | One-cycle block completion pulse |
| done_code | output | 4 | Completion code, valid with `done_pulse` |

## Verification
The bench builds the engine with its defaults: a 2 KB parameter RAM (512 words) and a 4-bit event counter. At this size, sets can be placed at several 24-byte offsets and linked to one another. Four back-to-back events can also be queued behind a link fetch without reaching saturation. With the memory stall pattern switched on, every request is held for several cycles, which tests the hold rules on the memory port during frame-sync bursts.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    parameter int unsigned DMA_AW = 32;
    parameter int unsigned DMA_DW = 32;
    parameter int unsigned CNT_W  = 16;
    parameter int unsigned SET_WORDS = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_WAIT,
        ST_RD,
        ST_WR
    } eng_state_e;

    typedef struct packed {
        logic [3:0] code;
        logic       link;
        logic       tc_en;
        logic       fsync;
        logic [1:0] dmode;
        logic [1:0] smode;
        logic [1:0] esize;
    } opt_t;

    typedef struct packed {
        opt_t              opt;
        logic [DMA_AW-1:0] src;
        logic [DMA_AW-1:0] dst;
        logic [CNT_W-1:0]  ecnt;
        logic [CNT_W-1:0]  fcnt;
        logic [CNT_W-1:0]  rld;
        logic [15:0]       link;
    } pset_t;

    function automatic opt_t decode_opt(input logic [DMA_DW-1:0] w);
        opt_t o;
        o.esize = w[1:0];
        o.smode = w[3:2];
        o.dmode = w[5:4];
        o.fsync = w[6];
        o.tc_en = w[7];
        o.link  = w[8];
        o.code  = w[15:12];
        return o;
    endfunction

    function automatic logic [DMA_DW-1:0] size_mask(input logic [1:0] esize);
        case (esize)
            2'd0:    return DMA_DW'(32'h0000_00FF);
            2'd1:    return DMA_DW'(32'h0000_FFFF);
            default: return '1;
        endcase
    endfunction

endpackage

// File: rtl/dma_param_ram.sv
module dma_param_ram #(
    parameter int unsigned BYTES = 2048,
    localparam int unsigned WORDS = BYTES / 4,
    localparam int unsigned IW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [31:0]   wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [31:0]   rd_data
);

    logic [31:0] mem [WORDS];
    logic [31:0] rd_data_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
        rd_data_q <= mem[rd_idx];
    end

    assign rd_data = rd_data_q;

endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_chan_pkg::*;
(
    input  logic [DMA_AW-1:0] addr,
    input  logic [1:0]        mode,
    input  logic [1:0]        esize,
    output logic [DMA_AW-1:0] addr_nxt
);

    logic [DMA_AW-1:0] step;

    always_comb begin
        case (esize)
            2'd0:    step = DMA_AW'(1);
            2'd1:    step = DMA_AW'(2);
            default: step = DMA_AW'(4);
        endcase
        case (mode)
            2'd1:    addr_nxt = addr + step;
            2'd2:    addr_nxt = addr - step;
            default: addr_nxt = addr;
        endcase
    end

endmodule

// File: rtl/dma_evt_pend.sv
module dma_evt_pend #(
    parameter int unsigned W = 4,
    localparam logic [W-1:0] MAXV = '1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    input  logic dec,
    output logic has
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && !dec) begin
            if (cnt_q != MAXV) cnt_d = cnt_q + 1'b1;
        end else if (dec && !inc) begin
            if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign has = (cnt_q != '0);

    // Saturation: a full counter stays full when only an event arrives
    assert_pend_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == MAXV && inc && !dec && !clr) |=> (cnt_q == MAXV));

    // An event added to an empty counter is visible next cycle
    assert_pend_seen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec && !clr) |=> has);

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int unsigned PRAM_BYTES = 2048,
    parameter int unsigned PEND_W = 4,
    localparam int unsigned PIDX_W = $clog2(PRAM_BYTES / 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [PIDX_W-1:0] host_waddr,
    input  logic [31:0]       host_wdata,
    input  logic              start,
    input  logic [15:0]       start_addr,
    input  logic              sync_evt,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [DMA_AW-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [DMA_DW-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DMA_DW-1:0] mem_rdata,
    output logic              busy,
    output logic              done_pulse,
    output logic [3:0]        done_code
);

    localparam logic [2:0] LD_LAST = 3'(SET_WORDS);

    typedef struct packed {
        eng_state_e        st;
        logic [2:0]        ld_idx;
        logic [PIDX_W-1:0] base;
        pset_t             ps;
        logic [DMA_DW-1:0] data;
        logic              done;
        logic [3:0]        code;
    } eng_reg_t;

    eng_reg_t q, d;

    logic [PIDX_W-1:0] pram_rd_idx;
    logic [31:0]       pram_rd_data;
    logic              pend_has;
    logic              consume;
    logic              pend_clr;
    logic [DMA_AW-1:0] step_in  [2];
    logic [1:0]        step_mode[2];
    logic [DMA_AW-1:0] step_out [2];

    dma_param_ram #(.BYTES(PRAM_BYTES)) u_pram (
        .clk     (clk),
        .wr_en   (host_we),
        .wr_idx  (host_waddr),
        .wr_data (host_wdata),
        .rd_idx  (pram_rd_idx),
        .rd_data (pram_rd_data)
    );

    assign pend_clr = start && (q.st == ST_IDLE);

    dma_evt_pend #(.W(PEND_W)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pend_clr),
        .inc   (sync_evt && (q.st != ST_IDLE)),
        .dec   (consume),
        .has   (pend_has)
    );

    assign step_in[0]   = q.ps.src;
    assign step_mode[0] = q.ps.opt.smode;
    assign step_in[1]   = q.ps.dst;
    assign step_mode[1] = q.ps.opt.dmode;

    for (genvar gi = 0; gi < 2; gi++) begin : g_step
        dma_addr_step u_step (
            .addr     (step_in[gi]),
            .mode     (step_mode[gi]),
            .esize    (q.ps.opt.esize),
            .addr_nxt (step_out[gi])
        );
    end

    always_comb begin
        d = q;
        d.done = 1'b0;
        consume = 1'b0;
        pram_rd_idx = q.base + PIDX_W'(q.ld_idx);

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st = ST_LOAD;
                    d.ld_idx = '0;
                    d.base = start_addr[PIDX_W+1:2];
                end
            end
            ST_LOAD: begin
                case (q.ld_idx)
                    3'd1: d.ps.opt = decode_opt(pram_rd_data);
                    3'd2: d.ps.src = pram_rd_data;
                    3'd3: d.ps.dst = pram_rd_data;
                    3'd4: begin
                        d.ps.ecnt = pram_rd_data[CNT_W-1:0];
                        d.ps.fcnt = pram_rd_data[16 +: CNT_W];
                    end
                    3'd5: d.ps.rld = pram_rd_data[CNT_W-1:0];
                    3'd6: d.ps.link = pram_rd_data[15:0];
                    default: ;
                endcase
                if (q.ld_idx == LD_LAST) d.st = ST_WAIT;
                else                     d.ld_idx = q.ld_idx + 3'd1;
            end
            ST_WAIT: begin
                if (pend_has) begin
                    consume = 1'b1;
                    d.st = ST_RD;
                end
            end
            ST_RD: begin
                if (mem_ready) begin
                    d.data = mem_rdata & size_mask(q.ps.opt.esize);
                    d.st = ST_WR;
                end
            end
            ST_WR: begin
                if (mem_ready) begin
                    d.ps.src = step_out[0];
                    d.ps.dst = step_out[1];
                    if (q.ps.ecnt <= CNT_W'(1)) begin
                        d.ps.ecnt = q.ps.rld;
                        if (q.ps.fcnt == '0) begin
                            d.done = q.ps.opt.tc_en;
                            d.code = q.ps.opt.code;
                            if (q.ps.opt.link) begin
                                d.st = ST_LOAD;
                                d.ld_idx = '0;
                                d.base = q.ps.link[PIDX_W+1:2];
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else begin
                            d.ps.fcnt = q.ps.fcnt - 1'b1;
                            d.st = ST_WAIT;
                        end
                    end else begin
                        d.ps.ecnt = q.ps.ecnt - 1'b1;
                        d.st = q.ps.opt.fsync ? ST_RD : ST_WAIT;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign mem_valid  = (q.st == ST_RD) || (q.st == ST_WR);
    assign mem_write  = (q.st == ST_WR);
    assign mem_addr   = (q.st == ST_WR) ? q.ps.dst : q.ps.src;
    assign mem_size   = q.ps.opt.esize;
    assign mem_wdata  = q.data;
    assign busy       = (q.st != ST_IDLE);
    assign done_pulse = q.done;
    assign done_code  = q.code;

    logic unused_ok;
    assign unused_ok = ^{start_addr[1:0], start_addr[15:PIDX_W+2],
                         pram_rd_data[31:16], q.ps.link[1:0], q.ps.link[15:PIDX_W+2]};

    // A stalled request keeps its address, direction and data
    assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)));

    // A stalled request leaves both counters untouched
    assert_stall_cnt_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> ($stable(q.ps.ecnt) && $stable(q.ps.fcnt)));

    // Completion is a single-cycle pulse
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    // Hold mode keeps the source address across a completed element
    assert_src_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_write && mem_ready && (q.ps.opt.smode == 2'd0)) |=>
            $stable(q.ps.src));

    // Without the link bit, completion leaves the engine idle
    assert_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_write && mem_ready && q.ps.ecnt <= CNT_W'(1) && q.ps.fcnt == '0 && !q.ps.opt.link)
            |=> !busy);

endmodule

// File: tb/sim_dma_chan_engine.sv
module sim_dma_chan_engine;

    localparam int PIDX_W = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [PIDX_W-1:0] host_waddr = '0;
    logic [31:0] host_wdata = '0;
    logic        start = 1'b0;
    logic [15:0] start_addr = '0;
    logic        sync_evt = 1'b0;
    logic        mem_valid, mem_write, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic        busy, done_pulse;
    logic [3:0]  done_code;

    always #10 clk = ~clk;

    dma_chan_engine u0 (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
        .start(start), .start_addr(start_addr), .sync_evt(sync_evt),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .busy(busy), .done_pulse(done_pulse),
        .done_code(done_code)
    );

    logic [7:0] mem [1024];
    int n_chk = 0, n_bad = 0;
    int wr_cnt = 0, done_cnt = 0, stall_viol = 0;
    logic [3:0] last_code = '0;
    bit stall_mode = 1'b0;
    int rdy_ctr = 0;

    always @(negedge clk) begin
        rdy_ctr <= rdy_ctr + 1;
        mem_ready <= !stall_mode || (rdy_ctr % 3 == 0);
    end

    always_comb begin
        logic [9:0] a;
        a = mem_addr[9:0];
        mem_rdata = {mem[10'(a + 10'd3)], mem[10'(a + 10'd2)], mem[10'(a + 10'd1)], mem[a]};
    end

    logic        prev_stall = 1'b0;
    logic [31:0] prev_addr = '0, prev_wdata = '0;
    logic        prev_write = 1'b0;

    always @(posedge clk) begin
        if (mem_valid && mem_write && mem_ready) begin
            for (int k = 0; k < (1 << mem_size) && k < 4; k++)
                mem[10'(mem_addr[9:0] + 10'(k))] <= mem_wdata[8*k +: 8];
            wr_cnt = wr_cnt + 1;
        end
        if (done_pulse) begin
            done_cnt = done_cnt + 1;
            last_code = done_code;
        end
        if (prev_stall && !(mem_valid && mem_addr == prev_addr &&
                            mem_write == prev_write && mem_wdata == prev_wdata))
            stall_viol = stall_viol + 1;
        prev_stall = mem_valid && !mem_ready;
        prev_addr = mem_addr;
        prev_write = mem_write;
        prev_wdata = mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_word(input int idx, input logic [31:0] w);
        @(negedge clk);
        host_we = 1'b1; host_waddr = PIDX_W'(idx); host_wdata = w;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic put_set(input int byte_addr, input logic [31:0] w0, w1, w2, w3, w4, w5);
        put_word(byte_addr / 4 + 0, w0);
        put_word(byte_addr / 4 + 1, w1);
        put_word(byte_addr / 4 + 2, w2);
        put_word(byte_addr / 4 + 3, w3);
        put_word(byte_addr / 4 + 4, w4);
        put_word(byte_addr / 4 + 5, w5);
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) ^ (a >> 3));
    endfunction

    task automatic fill(input int a0, input int n, input bit fixed, input logic [7:0] v);
        @(negedge clk);
        for (int i = 0; i < n; i++) mem[a0 + i] <= fixed ? v : pat(a0 + i);
    endtask

    task automatic kick(input int byte_addr);
        @(negedge clk);
        start = 1'b1; start_addr = 16'(byte_addr);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse_sync;
        @(negedge clk);
        sync_evt = 1'b1;
        @(negedge clk);
        sync_evt = 1'b0;
    endtask

    task automatic wait_idle;
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(mem_valid == 1'b0, "R1", "mem_valid after reset", mem_valid, 0);
        chk(done_pulse == 1'b0, "R1", "done_pulse after reset", done_pulse, 0);
    endtask

    // element sync, 32 bit, increment both, completion code 5, no link
    task automatic t_element;
        int w0, d0;
        fill(32'h100, 16, 0, 8'h0);
        fill(32'h200, 16, 1, 8'hEE);
        put_set(0, 32'h5096, 32'h100, 32'h200, {16'd0, 16'd4}, 32'd4, 32'd0);
        w0 = wr_cnt; d0 = done_cnt;
        kick(0);
        tick(1);
        chk(busy == 1'b1, "R2", "busy after start", busy, 1);
        tick(12);
        chk(wr_cnt - w0 == 0, "R5", "writes without event", wr_cnt - w0, 0);
        pulse_sync(); tick(8);
        chk(wr_cnt - w0 == 1, "R5", "writes after one event", wr_cnt - w0, 1);
        for (int i = 0; i < 3; i++) begin pulse_sync(); tick(8); end
        wait_idle(); tick(2);
        chk(wr_cnt - w0 == 4, "R6", "writes for block", wr_cnt - w0, 4);
        for (int i = 0; i < 16; i++)
            chk(mem[32'h200 + i] == pat(32'h100 + i), "R4", "increment copy byte",
                mem[32'h200 + i], pat(32'h100 + i));
        chk(done_cnt - d0 == 1, "R9", "completion pulses", done_cnt - d0, 1);
        chk(last_code == 4'd5, "R9", "completion code", last_code, 5);
        chk(busy == 1'b0, "R10", "idle after unlinked block", busy, 0);
        pulse_sync(); tick(10);
        chk(wr_cnt - w0 == 4, "R10", "event after stop moves nothing", wr_cnt - w0, 4);
    endtask

    // frame sync, 16 bit, source decrement, destination hold, 2 frames of 3
    task automatic t_frame;
        int w0, d0;
        fill(32'h130, 32, 0, 8'h0);
        fill(32'h300, 4, 1, 8'hEE);
        put_set(24, 32'h49, 32'h140, 32'h300, {16'd1, 16'd3}, 32'd3, 32'd0);
        w0 = wr_cnt; d0 = done_cnt;
        kick(24); tick(12);
        pulse_sync(); tick(20);
        chk(wr_cnt - w0 == 3, "R7", "frame burst writes", wr_cnt - w0, 3);
        chk(busy == 1'b1, "R6", "second frame pending", busy, 1);
        pulse_sync(); wait_idle(); tick(2);
        chk(wr_cnt - w0 == 6, "R6", "two frames of three", wr_cnt - w0, 6);
        chk(mem[32'h300] == pat(32'h136), "R4", "hold dst low byte", mem[32'h300], pat(32'h136));
        chk(mem[32'h301] == pat(32'h137), "R4", "hold dst high byte", mem[32'h301], pat(32'h137));
        chk(mem[32'h302] == 8'hEE, "R3", "halfword leaves byte 2", mem[32'h302], 8'hEE);
        chk(done_cnt - d0 == 0, "R9", "no pulse when disabled", done_cnt - d0, 0);
    endtask

    // linked byte transfers, events queued back to back
    task automatic t_link;
        int w0, d0;
        fill(32'h180, 4, 0, 8'h0);
        fill(32'h1A0, 4, 0, 8'h0);
        fill(32'h280, 8, 1, 8'hEE);
        put_set(48, 32'h114, 32'h180, 32'h280, {16'd0, 16'd2}, 32'd2, 32'd72);
        put_set(72, 32'h9094, 32'h1A0, 32'h284, {16'd0, 16'd2}, 32'd2, 32'd0);
        w0 = wr_cnt; d0 = done_cnt;
        kick(48); tick(10);
        @(negedge clk); sync_evt = 1'b1;
        tick(4);
        sync_evt = 1'b0;
        wait_idle(); tick(2);
        chk(wr_cnt - w0 == 4, "R8", "queued events all serviced", wr_cnt - w0, 4);
        chk(mem[32'h281] == pat(32'h181), "R10", "first set data", mem[32'h281], pat(32'h181));
        chk(mem[32'h285] == pat(32'h1A1), "R10", "linked set data", mem[32'h285], pat(32'h1A1));
        chk(mem[32'h282] == 8'hEE, "R3", "byte width untouched", mem[32'h282], 8'hEE);
        chk(done_cnt - d0 == 1, "R9", "pulse only from linked set", done_cnt - d0, 1);
        chk(last_code == 4'd9, "R9", "linked set code", last_code, 9);
    endtask

    // frame burst with a stalling memory
    task automatic t_stall;
        int w0;
        fill(32'h1C0, 16, 0, 8'h0);
        fill(32'h3C0, 16, 1, 8'hEE);
        put_set(96, 32'h30D6, 32'h1C0, 32'h3C0, {16'd0, 16'd4}, 32'd4, 32'd0);
        stall_mode = 1'b1;
        w0 = wr_cnt;
        kick(96); tick(10);
        pulse_sync(); wait_idle(); tick(2);
        stall_mode = 1'b0;
        chk(wr_cnt - w0 == 4, "R11", "writes under stall", wr_cnt - w0, 4);
        chk(stall_viol == 0, "R11", "request changed while stalled", stall_viol, 0);
        for (int i = 0; i < 16; i += 5)
            chk(mem[32'h3C0 + i] == pat(32'h1C0 + i), "R11", "stalled copy byte",
                mem[32'h3C0 + i], pat(32'h1C0 + i));
        chk(last_code == 4'd3, "R9", "stall run code", last_code, 3);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        tick(4);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_element();
        t_frame();
        t_link();
        t_stall();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule